// File: doc/BRIEF.md
# Ethernet transmit frame packer

This block turns one outgoing Ethernet frame, already stored in a word-wide single-frame transmit buffer, into a nibble stream for a MII-style transmit interface. The buffer holds a small header carrying the payload length, then the destination and source addresses, the length/type field and the payload, packed four octets to a 32-bit word. The packer reads the buffer through a combinational word read port: the word address it drives selects the data returned in the same cycle.

After a start request it walks the frame octet by octet and sends each octet as two nibbles, low half first. When padding is enabled, it appends zero octets so that payload plus pad reaches the 46-octet minimum. It then appends a frame check sequence. With FCS insertion enabled, this is a CRC-32 computed one nibble per cycle over every octet sent. With insertion disabled, it is four octets copied unchanged from the buffer directly after the payload, which may start mid-word. Preamble and start-of-frame delimiter generation, collision handling and register access are handled elsewhere.

Top module: `eth_tx_packer`

## Requirements
- R1: Buffer word 0 holds the payload length L, low byte in bits 7:0 and high byte in bits 15:8. Every buffer byte from byte position 2 on is a frame octet in increasing byte position, where byte position p sits in word p/4 at bits 8*(p%4)+7 : 8*(p%4). The first 14+L frame octets sent (addresses, length/type, payload) are buffer positions 2 through 15+L.
- R2: Each octet is sent as two nibbles on txd_o, bits 3:0 first and then bits 7:4. busy_o rises after the clock edge that samples start_i. txv_o rises one cycle later and stays high without gaps, one nibble per cycle, until the last FCS nibble.
- R3: With pad_en_i high at start and L below 46, 46-L zero octets follow the payload. With L of 46 or more, or with pad_en_i low, no pad octet is sent.
- R4: With fcs_en_i high at start, the last four octets are the CRC-32 of every octet sent before them, including pad. The CRC uses the reflected polynomial 0xEDB88320 and a register preset to all ones. The complement of the register is sent least significant octet first.
- R5: With fcs_en_i low at start, the last four octets are buffer positions 16+L through 19+L, copied unchanged even when they straddle a word boundary. They follow any pad octets.
- R6: A frame is exactly 2*(14+L+P+4) nibbles long, where P is the pad count. Payload lengths up to 2032 bytes are accepted with the default 512-word buffer, and no 1500-byte limit applies.
- R7: done_o is high for exactly one cycle, the cycle right after the last nibble. busy_o is low in that cycle and high in every cycle that carries a nibble.
- R8: start_i is ignored while busy_o is high. pad_en_i, fcs_en_i and the buffer length field are sampled only when a frame is accepted, and later changes do not alter the stream in progress.
- R9: During and right after reset, busy_o, done_o and txv_o are low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to send the frame held in the buffer |
| pad_en_i | input | 1 | Pad short payloads to 46 octets |
| fcs_en_i | input | 1 | Append the computed CRC-32 (low: pass the buffer's FCS through) |
| busy_o | output | 1 | A frame is being sent |
| done_o | output | 1 | One-cycle pulse after the final nibble |
| buf_addr_o | output | $clog2(BUF_WORDS) | Buffer word address |
| buf_data_i | input | 32 | Buffer word at buf_addr_o, same cycle |
| txd_o | output | 4 | Transmit nibble |
| txv_o | output | 1 | Transmit nibble valid |

## Verification
The hardest case to reach is a pass-through FCS that starts at each of the four byte lanes, combined with a pad run that ends exactly at 46 octets or is not needed. Only specific payload lengths put the FCS octets across a word boundary after a pad. The bench sweeps every payload length from 0 to 60 under all four pad/FCS settings, so every lane offset and both sides of the 46-octet boundary occur. It adds a maximum-length frame that fills the buffer to its last word. On a few frames it toggles the enables, rewrites the length field and re-pulses start mid-frame, to show that the stream does not change.

// File: rtl/eth_tx_pkg.sv
package eth_tx_pkg;

  localparam int LEN_W      = 16;
  localparam int HDR_OCTETS = 14;
  localparam int MIN_DATA   = 46;
  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_BODY = 3'd1,
    PH_PAD  = 3'd2,
    PH_FCS  = 3'd3,
    PH_TAIL = 3'd4
  } phase_e;

  // Advance a reflected CRC-32 register by one nibble, bit 0 first.
  function automatic logic [31:0] crc_nib_step(input logic [31:0] c, input logic [3:0] d);
    logic [31:0] r;
    r = c;
    for (int i = 0; i < 4; i++) begin
      if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
      else             r = r >> 1;
    end
    return r;
  endfunction

endpackage

// File: rtl/eth_tx_lane_sel.sv
module eth_tx_lane_sel #(
  parameter int LANES = 4
) (
  input  logic [8*LANES-1:0]         word_i,
  input  logic [$clog2(LANES)-1:0]   lane_i,
  input  logic                       half_i,
  output logic [3:0]                 nib_o
);

  logic [7:0] lanes [LANES];
  logic [7:0] octet;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = word_i[8*g +: 8];
  end

  assign octet = lanes[lane_i];
  assign nib_o = half_i ? octet[7:4] : octet[3:0];

endmodule

// File: rtl/eth_tx_crc_nib.sv
module eth_tx_crc_nib
  import eth_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init_i,
  input  logic        adv_i,
  input  logic [3:0]  nib_i,
  output logic [31:0] crc_o
);

  logic [31:0] crc_q, crc_d;
  logic        crc_en;

  assign crc_en = init_i | adv_i;

  always_comb begin
    if (init_i) crc_d = '1;
    else        crc_d = crc_nib_step(crc_q, nib_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      crc_q <= '1;
    else if (crc_en) crc_q <= crc_d;
  end

  assign crc_o = crc_q;

endmodule

// File: rtl/eth_tx_seq.sv
module eth_tx_seq
  import eth_tx_pkg::*;
#(
  parameter int BUF_WORDS = 512
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          pad_en_i,
  input  logic                          fcs_en_i,
  input  logic [LEN_W-1:0]              len_i,
  output phase_e                        phase_o,
  output logic                          half_o,
  output logic [1:0]                    fidx_o,
  output logic [$clog2(BUF_WORDS)+1:0]  bptr_o,
  output logic                          fcs_sel_o,
  output logic                          done_o
);

  localparam int AW = $clog2(BUF_WORDS);
  localparam int PW = AW + 2;
  localparam int RW = LEN_W + 1;
  localparam logic [LEN_W-1:0] MIN_DATA_L = LEN_W'(MIN_DATA);

  phase_e          phase_q, phase_d;
  logic            half_q, half_d;
  logic [RW-1:0]   rem_q, rem_d;
  logic [PW-1:0]   bptr_q, bptr_d;
  logic [1:0]      fidx_q, fidx_d;
  logic            done_q, done_d;
  logic            pad_q, fcs_q;
  logic [LEN_W-1:0] len_q;

  logic            accept;
  logic            need_pad;
  logic [RW-1:0]   pad_m1;

  assign accept   = (phase_q == PH_IDLE) && start_i;
  assign need_pad = pad_q && (len_q < MIN_DATA_L);
  assign pad_m1   = RW'(MIN_DATA - 1) - {1'b0, len_q};

  always_comb begin
    phase_d = phase_q;
    half_d  = half_q;
    rem_d   = rem_q;
    bptr_d  = bptr_q;
    fidx_d  = fidx_q;
    done_d  = 1'b0;
    case (phase_q)
      PH_IDLE: begin
        if (start_i) begin
          phase_d = PH_BODY;
          half_d  = 1'b0;
          rem_d   = {1'b0, len_i} + RW'(HDR_OCTETS - 1);
          bptr_d  = PW'(2);
          fidx_d  = 2'd0;
        end
      end
      PH_BODY: begin
        half_d = ~half_q;
        if (half_q) begin
          bptr_d = bptr_q + PW'(1);
          if (rem_q == '0) begin
            if (need_pad) begin
              phase_d = PH_PAD;
              rem_d   = pad_m1;
            end else begin
              phase_d = PH_FCS;
            end
          end else begin
            rem_d = rem_q - RW'(1);
          end
        end
      end
      PH_PAD: begin
        half_d = ~half_q;
        if (half_q) begin
          if (rem_q == '0) phase_d = PH_FCS;
          else             rem_d   = rem_q - RW'(1);
        end
      end
      PH_FCS: begin
        half_d = ~half_q;
        if (half_q) begin
          bptr_d = bptr_q + PW'(1);
          fidx_d = fidx_q + 2'd1;
          if (fidx_q == 2'd3) phase_d = PH_TAIL;
        end
      end
      PH_TAIL: begin
        phase_d = PH_IDLE;
        done_d  = 1'b1;
      end
      default: phase_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      half_q  <= 1'b0;
      rem_q   <= '0;
      bptr_q  <= '0;
      fidx_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      half_q  <= half_d;
      rem_q   <= rem_d;
      bptr_q  <= bptr_d;
      fidx_q  <= fidx_d;
      done_q  <= done_d;
    end
  end

  // Frame configuration, loaded only when a frame is accepted.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pad_q <= 1'b0;
      fcs_q <= 1'b0;
      len_q <= '0;
    end else if (accept) begin
      pad_q <= pad_en_i;
      fcs_q <= fcs_en_i;
      len_q <= len_i;
    end
  end

  assign phase_o   = phase_q;
  assign half_o    = half_q;
  assign fidx_o    = fidx_q;
  assign bptr_o    = bptr_q;
  assign fcs_sel_o = fcs_q;
  assign done_o    = done_q;

  p_cfg_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q != PH_IDLE) |=> ($stable(len_q) && $stable(pad_q) && $stable(fcs_q)));

  p_pad_only_short_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_PAD) |-> (pad_q && (len_q < MIN_DATA_L)));

  p_fcs_leads_to_tail_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_FCS) |=> (phase_q == PH_FCS || phase_q == PH_TAIL));

endmodule

// File: rtl/eth_tx_packer.sv
module eth_tx_packer
  import eth_tx_pkg::*;
#(
  parameter int BUF_WORDS = 512
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start_i,
  input  logic                          pad_en_i,
  input  logic                          fcs_en_i,
  output logic                          busy_o,
  output logic                          done_o,
  output logic [$clog2(BUF_WORDS)-1:0]  buf_addr_o,
  input  logic [31:0]                   buf_data_i,
  output logic [3:0]                    txd_o,
  output logic                          txv_o
);

  localparam int AW = $clog2(BUF_WORDS);
  localparam int PW = AW + 2;

  phase_e        phase;
  logic          half;
  logic [1:0]    fidx;
  logic [PW-1:0] bptr;
  logic          fcs_sel;
  logic [3:0]    body_nib;
  logic [3:0]    fcs_nib;
  logic [4:0]    fcs_sh;
  logic [31:0]   crc;
  logic          crc_init, crc_adv;
  logic          emit;
  logic [3:0]    nib_d;
  logic [3:0]    txd_q;
  logic          txv_q;

  eth_tx_seq #(.BUF_WORDS(BUF_WORDS)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .pad_en_i  (pad_en_i),
    .fcs_en_i  (fcs_en_i),
    .len_i     (buf_data_i[LEN_W-1:0]),
    .phase_o   (phase),
    .half_o    (half),
    .fidx_o    (fidx),
    .bptr_o    (bptr),
    .fcs_sel_o (fcs_sel),
    .done_o    (done_o)
  );

  assign buf_addr_o = (phase == PH_IDLE) ? '0 : bptr[PW-1:2];

  eth_tx_lane_sel #(.LANES(4)) u_lane (
    .word_i (buf_data_i),
    .lane_i (bptr[1:0]),
    .half_i (half),
    .nib_o  (body_nib)
  );

  assign crc_init = (phase == PH_IDLE) && start_i;
  assign crc_adv  = (phase == PH_BODY) || (phase == PH_PAD);

  eth_tx_crc_nib u_crc (
    .clk    (clk),
    .rst_n  (rst_n),
    .init_i (crc_init),
    .adv_i  (crc_adv),
    .nib_i  (nib_d),
    .crc_o  (crc)
  );

  assign fcs_sh  = {fidx, half, 2'b00};
  assign fcs_nib = ~crc[fcs_sh +: 4];
  assign emit    = (phase == PH_BODY) || (phase == PH_PAD) || (phase == PH_FCS);

  always_comb begin
    case (phase)
      PH_BODY: nib_d = body_nib;
      PH_PAD:  nib_d = 4'h0;
      PH_FCS:  nib_d = fcs_sel ? fcs_nib : body_nib;
      default: nib_d = 4'h0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      txd_q <= '0;
      txv_q <= 1'b0;
    end else begin
      txv_q <= emit;
      if (emit) txd_q <= nib_d;
    end
  end

  assign txd_o  = txd_q;
  assign txv_o  = txv_q;
  assign busy_o = (phase != PH_IDLE);

  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && !txv_o));

  p_valid_in_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    txv_o |-> busy_o);

  p_pad_is_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAD) |=> (txv_o && txd_o == 4'h0));

  p_crc_frozen_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_FCS) |=> $stable(crc));

endmodule

// File: tb/eth_tx_packer_bench.sv
module eth_tx_packer_bench;

  localparam int BUF_WORDS = 512;
  localparam int AW        = $clog2(BUF_WORDS);
  localparam logic [31:0] POLY = 32'hEDB88320;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start, pad_en, fcs_en;
  logic          busy, done;
  logic [AW-1:0] buf_addr;
  logic [31:0]   buf_data;
  logic [3:0]    txd;
  logic          txv;

  logic [31:0] mem [BUF_WORDS];
  logic [7:0]  exp_b [2100];
  logic [3:0]  got   [4200];
  int n_exp, n_body, n_pad;
  int n_checks = 0;
  int n_errs   = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  assign buf_data = mem[buf_addr];

  eth_tx_packer #(.BUF_WORDS(BUF_WORDS)) u_eth_tx_packer (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start),
    .pad_en_i   (pad_en),
    .fcs_en_i   (fcs_en),
    .busy_o     (busy),
    .done_o     (done),
    .buf_addr_o (buf_addr),
    .buf_data_i (buf_data),
    .txd_o      (txd),
    .txv_o      (txv)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input int pos, input int seed);
    return 8'(pos * 37 + seed * 11 + 5 + (pos >> 3));
  endfunction

  function automatic logic [7:0] buf_byte(input int pos);
    return mem[pos >> 2][8 * (pos & 3) +: 8];
  endfunction

  task automatic fill(input int len, input int seed);
    for (int w = 0; w < BUF_WORDS; w++) begin
      for (int l = 0; l < 4; l++) begin
        int p;
        p = w * 4 + l;
        if (p == 0)      mem[w][7:0]       = 8'(len);
        else if (p == 1) mem[w][15:8]      = 8'(len >> 8);
        else             mem[w][8*l +: 8]  = pat(p, seed);
      end
    end
  endtask

  task automatic build_exp(input int len, input bit pad, input bit fcs);
    logic [31:0] c;
    n_exp  = 0;
    n_body = 14 + len;
    for (int k = 0; k < n_body; k++) exp_b[n_exp++] = buf_byte(k + 2);
    n_pad = (pad && len < 46) ? 46 - len : 0;
    for (int k = 0; k < n_pad; k++) exp_b[n_exp++] = 8'h00;
    if (fcs) begin
      c = 32'hFFFFFFFF;
      for (int k = 0; k < n_exp; k++) begin
        for (int b = 0; b < 8; b++) begin
          if (c[0] ^ exp_b[k][b]) c = (c >> 1) ^ POLY;
          else                    c = c >> 1;
        end
      end
      c = ~c;
      for (int m = 0; m < 4; m++) exp_b[n_exp + m] = c[8*m +: 8];
    end else begin
      for (int m = 0; m < 4; m++) exp_b[n_exp + m] = buf_byte(16 + len + m);
    end
    n_exp = n_exp + 4;
  endtask

  task automatic run_frame(input int len, input bit pad, input bit fcs,
                           input int seed, input bit disturb);
    int n_nib, n_got, first_c, last_c, done_cnt, done_c;
    int mis_body, mis_pad, mis_fcs, mis_total;
    bit busy0, txv0, busy_done, busy_last;
    string fr;
    fill(len, seed);
    build_exp(len, pad, fcs);
    n_nib = 2 * n_exp;
    n_got = 0; first_c = -1; last_c = -1; done_cnt = 0; done_c = -1;
    busy0 = 0; txv0 = 0; busy_done = 1; busy_last = 0;
    fr = $sformatf("L=%0d pad=%0d fcs=%0d", len, pad, fcs);

    @(negedge clk);
    start = 1'b1; pad_en = pad; fcs_en = fcs;
    @(negedge clk);
    start = 1'b0;
    if (disturb) begin
      pad_en = ~pad;
      fcs_en = ~fcs;
    end
    for (int c = 0; c < n_nib + 4; c++) begin
      if (c == 0) begin busy0 = busy; txv0 = txv; end
      if (c == n_nib) busy_last = busy;
      if (txv) begin
        if (n_got < 4200) got[n_got] = txd;
        n_got++;
        if (first_c < 0) first_c = c;
        last_c = c;
      end
      if (done) begin
        done_cnt++;
        done_c    = c;
        busy_done = busy;
      end
      if (disturb && c == 10) begin
        start = 1'b1;
        mem[0][15:0] = mem[0][15:0] ^ 16'h0005;
      end
      if (disturb && c == 11) start = 1'b0;
      @(negedge clk);
    end

    mis_body = 0; mis_pad = 0; mis_fcs = 0;
    for (int i = 0; i < n_nib && i < n_got; i++) begin
      logic [3:0] e;
      e = (i % 2 == 0) ? exp_b[i / 2][3:0] : exp_b[i / 2][7:4];
      if (got[i] !== e) begin
        if (i / 2 < n_body)              mis_body++;
        else if (i / 2 < n_body + n_pad) mis_pad++;
        else                             mis_fcs++;
      end
    end
    mis_total = mis_body + mis_pad + mis_fcs;

    check(busy0 && !txv0, "R2", {"busy high, txv low one cycle after start ", fr},
          {busy0, txv0}, 2'b10);
    check(first_c == 1, "R2", {"first nibble cycle ", fr}, first_c, 1);
    check(n_got >= 2 && got[0] == exp_b[0][3:0] && got[1] == exp_b[0][7:4], "R2",
          {"low nibble before high nibble ", fr}, {got[0], got[1]}, {exp_b[0][3:0], exp_b[0][7:4]});
    check(n_got == n_nib && last_c == n_nib, "R6", {"nibble count / contiguity ", fr},
          n_got, n_nib);
    check(mis_body == 0, "R1", {"address/type/payload nibbles ", fr}, mis_body, 0);
    check(mis_pad == 0, "R3", {"pad nibbles ", fr}, mis_pad, 0);
    if (fcs) check(mis_fcs == 0, "R4", {"computed FCS nibbles ", fr}, mis_fcs, 0);
    else     check(mis_fcs == 0, "R5", {"pass-through FCS nibbles ", fr}, mis_fcs, 0);
    check(done_cnt == 1 && done_c == n_nib + 1, "R7", {"done single pulse after last nibble ", fr},
          done_c, n_nib + 1);
    check(!busy_done && busy_last, "R7", {"busy low at done, high on last nibble ", fr},
          {busy_done, busy_last}, 2'b01);
    if (disturb)
      check(mis_total == 0 && n_got == n_nib, "R8", {"stream unchanged by mid-frame start/enables ", fr},
            mis_total, 0);
    pad_en = 1'b0;
    fcs_en = 1'b0;
  endtask

  initial begin
    #(4 * 195000);
    if (!finished) begin
      n_errs++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start = 1'b0; pad_en = 1'b0; fcs_en = 1'b0;
    for (int w = 0; w < BUF_WORDS; w++) mem[w] = '0;
    repeat (3) @(negedge clk);
    check(!busy && !done && !txv, "R9", "outputs in reset", {busy, done, txv}, 3'b000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!busy && !done && !txv, "R9", "outputs after reset", {busy, done, txv}, 3'b000);

    // Sweep of payload lengths under every pad/FCS setting (R1 R3 R4 R5).
    for (int len = 0; len <= 60; len++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        run_frame(len, cfg[0], cfg[1], len + cfg, 1'b0);
      end
    end

    // Mid-frame disturbance (R8).
    for (int cfg = 0; cfg < 4; cfg++) begin
      run_frame(3, cfg[0], cfg[1], 77 + cfg, 1'b1);
      run_frame(50, cfg[0], cfg[1], 91 + cfg, 1'b1);
    end

    // Largest payload the buffer holds (R6).
    run_frame(2032, 1'b0, 1'b1, 5, 1'b0);
    run_frame(2032, 1'b1, 1'b1, 9, 1'b0);

    repeat (2) @(negedge clk);
    check(!busy && !txv, "R7", "idle after last frame", {busy, txv}, 2'b00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
    $finish;
  end

endmodule